// File: doc/BRIEF.md
# Output Stage Ramp Sequencer

This block sequences the power-up and power-down of a headphone output stage. Software controls it with a per-stage standby bit. When that bit is cleared, the sequencer walks the output level up from silence to the programmed gain code, one code per ramp tick. When the bit is set, it walks the level back down to zero. Each completed ramp raises a sticky done flag, one for up and one for down. Software clears the relevant flag before it toggles the standby bit, then polls until the hardware sets the flag again.

Two chip-wide controls sit above the per-stage bit. A chip standby bit forces the level to zero and holds the sequencer idle. A sleep bit pauses the ramp where it stands. A ramp tick input sets the step rate. With one code per tick, the number of ticks in a ramp equals the gain code, so software picks a tick rate that keeps the longest ramp well inside its polling timeout.

Top module: `ostg_ramp_seq`

## Requirements
- R1: After reset, the ramp level is 0 and both done flags are 0.
- R2: A 1-to-0 transition of `stage_sb` while `chip_sb` is 0 starts an up ramp. From then on, each ramp tick raises the level by one code until it equals `gain_code`. Once the ramp is complete, further ticks leave the level unchanged.
- R3: `up_done` is set by the tick that brings the level to `gain_code`. With a gain code of 0, the first tick sets it.
- R4: A 0-to-1 transition of `stage_sb` starts a down ramp. Each tick lowers the level by one code until it is 0. `dn_done` is set by the tick that reaches 0, and by the first tick if the level is already 0.
- R5: Each done flag stays at 1 until its own clear strobe is pulsed. `clr_up` affects only `up_done`, and `clr_dn` affects only `dn_done`. If a flag's set and its clear strobe fall in the same cycle, the flag ends up at 1.
- R6: If `stage_sb` changes direction during a ramp, the level steps from its current value in the new direction. Only the flag for the new direction is set at the end.
- R7: While `chip_sb` is 1, the level is 0 from the next cycle on. Ticks and `stage_sb` changes have no effect, and no done flag is set.
- R8: When `chip_sb` goes from 1 to 0 while `stage_sb` is 0, an up ramp starts.
- R9: While `sleep_req` is 1, ticks are ignored and the level holds. Ramping resumes with the first tick after `sleep_req` returns to 0.
- R10: A tick in the same cycle as a ramp start does not step the level. The first step comes with the next tick.
- R11: During an up ramp the target is the live `gain_code`. If the gain code is lowered below the current level, the level steps down toward it, and `up_done` is set when the two are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stage_sb | input | 1 | Output-stage standby: 0 powered, 1 standby |
| chip_sb | input | 1 | Chip standby: 1 forces level 0 and idles the sequencer |
| sleep_req | input | 1 | Sleep: 1 pauses the ramp |
| gain_code | input | GAIN_W | Programmed output gain code (0..31 by default) |
| ramp_tick | input | 1 | Single-cycle step strobe |
| clr_up | input | 1 | Strobe: clear `up_done` |
| clr_dn | input | 1 | Strobe: clear `dn_done` |
| up_done | output | 1 | Sticky ramp-up-complete flag |
| dn_done | output | 1 | Sticky ramp-down-complete flag |
| ramp_level | output | GAIN_W | Current output level code |

## Verification
Two pairs of events can land in the same clock cycle. The first pair is the final ramp tick, which sets a done flag, and a software clear strobe on that same flag. The bench pulses both in one cycle and expects the flag to read 1 afterwards. The second pair is a `stage_sb` edge and a ramp tick. The bench provokes this with an edge-plus-tick cycle and expects the level to be unchanged after it, with the first step arriving on the next tick. The sweep runs over every gain code and checks the level after each tick against the arithmetic value min(k, G) going up and max(G-k, 0) going down.

// File: rtl/ostg_pkg.sv
package ostg_pkg;

  typedef enum logic [1:0] {
    DIR_IDLE = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } ramp_dir_e;

  typedef struct packed {
    logic go_up;
    logic go_dn;
  } ramp_start_t;

  localparam int unsigned NUM_FLAGS = 2;
  localparam int unsigned FLAG_UP   = 0;
  localparam int unsigned FLAG_DN   = 1;

endpackage

// File: rtl/ostg_edge_trig.sv
module ostg_edge_trig
  import ostg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        stage_sb,
  input  logic        chip_sb,
  output ramp_start_t start
);

  logic sb_q;
  logic chip_q;

  // Both history bits reset to the standby state.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sb_q   <= 1'b1;
      chip_q <= 1'b1;
    end else begin
      sb_q   <= stage_sb;
      chip_q <= chip_sb;
    end
  end

  // Up: the stage leaves standby, or the chip leaves standby while the stage is powered.
  assign start.go_up = !chip_sb && !stage_sb && (sb_q || chip_q);
  // Down: the stage enters standby while the chip is awake.
  assign start.go_dn = !chip_sb && stage_sb && !sb_q;

endmodule

// File: rtl/ostg_stepper.sv
module ostg_stepper
  import ostg_pkg::*;
#(
  parameter int unsigned GAIN_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ramp_start_t       start,
  input  logic              tick,
  input  logic              sleep_req,
  input  logic              chip_sb,
  input  logic [GAIN_W-1:0] gain,
  output logic [GAIN_W-1:0] level,
  output logic              fin_up,
  output logic              fin_dn
);

  localparam logic [GAIN_W-1:0] LVL_ZERO = '0;

  // Move one code toward the target, or hold when already there.
  function automatic logic [GAIN_W-1:0] step_toward(
    input logic [GAIN_W-1:0] cur,
    input logic [GAIN_W-1:0] tgt
  );
    if (cur < tgt)      return cur + 1'b1;
    else if (cur > tgt) return cur - 1'b1;
    else                return cur;
  endfunction

  ramp_dir_e         dir_q;
  logic [GAIN_W-1:0] lvl_q;
  logic [GAIN_W-1:0] target;
  logic [GAIN_W-1:0] nxt;
  logic              advance;

  assign target  = (dir_q == DIR_UP) ? gain : LVL_ZERO;
  assign nxt     = step_toward(lvl_q, target);
  // A start in the same cycle takes priority over a tick.
  assign advance = tick && !sleep_req && !chip_sb && !start.go_up &&
                   !start.go_dn && (dir_q != DIR_IDLE);
  assign fin_up  = advance && (dir_q == DIR_UP)   && (nxt == gain);
  assign fin_dn  = advance && (dir_q == DIR_DOWN) && (nxt == LVL_ZERO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= LVL_ZERO;
      dir_q <= DIR_IDLE;
    end else if (chip_sb) begin
      lvl_q <= LVL_ZERO;
      dir_q <= DIR_IDLE;
    end else if (start.go_up) begin
      dir_q <= DIR_UP;
    end else if (start.go_dn) begin
      dir_q <= DIR_DOWN;
    end else if (advance) begin
      lvl_q <= nxt;
      if (fin_up || fin_dn) dir_q <= DIR_IDLE;
    end
  end

  assign level = lvl_q;

endmodule

// File: rtl/ostg_flags.sv
module ostg_flags
  import ostg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] set_i,
  input  logic [NUM_FLAGS-1:0] clr_i,
  output logic [NUM_FLAGS-1:0] flag_o
);

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    logic f_q;
    // When a set and a clear land together, the set wins.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        f_q <= 1'b0;
      else if (set_i[i]) f_q <= 1'b1;
      else if (clr_i[i]) f_q <= 1'b0;
    end
    assign flag_o[i] = f_q;
  end

endmodule

// File: rtl/ostg_ramp_seq.sv
module ostg_ramp_seq
  import ostg_pkg::*;
#(
  parameter int unsigned GAIN_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stage_sb,
  input  logic              chip_sb,
  input  logic              sleep_req,
  input  logic [GAIN_W-1:0] gain_code,
  input  logic              ramp_tick,
  input  logic              clr_up,
  input  logic              clr_dn,
  output logic              up_done,
  output logic              dn_done,
  output logic [GAIN_W-1:0] ramp_level
);

  ramp_start_t          start;
  logic                 go_up;
  logic                 go_dn;
  logic                 fin_up;
  logic                 fin_dn;
  logic [NUM_FLAGS-1:0] flag_set;
  logic [NUM_FLAGS-1:0] flag_clr;
  logic [NUM_FLAGS-1:0] flags;

  ostg_edge_trig trig_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .stage_sb (stage_sb),
    .chip_sb  (chip_sb),
    .start    (start)
  );

  // Start events, named for the checker.
  assign go_up = start.go_up;
  assign go_dn = start.go_dn;

  ostg_stepper #(.GAIN_W(GAIN_W)) step_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .tick      (ramp_tick),
    .sleep_req (sleep_req),
    .chip_sb   (chip_sb),
    .gain      (gain_code),
    .level     (ramp_level),
    .fin_up    (fin_up),
    .fin_dn    (fin_dn)
  );

  assign flag_set[FLAG_UP] = fin_up;
  assign flag_set[FLAG_DN] = fin_dn;
  assign flag_clr[FLAG_UP] = clr_up;
  assign flag_clr[FLAG_DN] = clr_dn;

  ostg_flags flags_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (flag_set),
    .clr_i  (flag_clr),
    .flag_o (flags)
  );

  assign up_done = flags[FLAG_UP];
  assign dn_done = flags[FLAG_DN];

endmodule

// File: rtl/ostg_ramp_seq_chk.sv
module ostg_ramp_seq_chk #(
  parameter int unsigned GAIN_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chip_sb,
  input logic              sleep_req,
  input logic [GAIN_W-1:0] gain_code,
  input logic              clr_up,
  input logic              up_done,
  input logic              dn_done,
  input logic [GAIN_W-1:0] ramp_level,
  input logic              go_up,
  input logic              go_dn,
  input logic              fin_up,
  input logic              fin_dn
);

  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_sb |=> (ramp_level == $past(ramp_level)) ||
                 (ramp_level == $past(ramp_level) + 1'b1) ||
                 (ramp_level + 1'b1 == $past(ramp_level)));

  assert_up_reaches_gain_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fin_up |=> up_done && (ramp_level == $past(gain_code)));

  assert_down_reaches_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fin_dn |=> dn_done && (ramp_level == '0));

  assert_up_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (up_done && !clr_up) |=> up_done);

  assert_one_finish_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fin_up, fin_dn}));

  assert_chip_sb_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chip_sb |=> (ramp_level == '0));

  assert_chip_sb_no_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_sb && !up_done && !dn_done) |=> (!up_done && !dn_done));

  assert_sleep_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && !chip_sb) |=> $stable(ramp_level));

  assert_start_no_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (go_up || go_dn) |=> $stable(ramp_level));

endmodule

bind ostg_ramp_seq ostg_ramp_seq_chk #(.GAIN_W(GAIN_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .chip_sb    (chip_sb),
  .sleep_req  (sleep_req),
  .gain_code  (gain_code),
  .clr_up     (clr_up),
  .up_done    (up_done),
  .dn_done    (dn_done),
  .ramp_level (ramp_level),
  .go_up      (go_up),
  .go_dn      (go_dn),
  .fin_up     (fin_up),
  .fin_dn     (fin_dn)
);

// File: tb/ostg_ramp_seq_tb_top.sv
module ostg_ramp_seq_tb_top;

  localparam int CLK_P  = 10;
  localparam int GAIN_W = 5;
  localparam int GMAX   = (1 << GAIN_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              stage_sb = 1'b1;
  logic              chip_sb = 1'b1;
  logic              sleep_req = 1'b0;
  logic [GAIN_W-1:0] gain_code = '0;
  logic              ramp_tick = 1'b0;
  logic              clr_up = 1'b0;
  logic              clr_dn = 1'b0;
  logic              up_done;
  logic              dn_done;
  logic [GAIN_W-1:0] ramp_level;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  ostg_ramp_seq #(.GAIN_W(GAIN_W)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .stage_sb   (stage_sb),
    .chip_sb    (chip_sb),
    .sleep_req  (sleep_req),
    .gain_code  (gain_code),
    .ramp_tick  (ramp_tick),
    .clr_up     (clr_up),
    .clr_dn     (clr_dn),
    .up_done    (up_done),
    .dn_done    (dn_done),
    .ramp_level (ramp_level)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic tick1();
    ramp_tick = 1'b1;
    @(negedge clk);
    ramp_tick = 1'b0;
  endtask

  task automatic clr_both();
    clr_up = 1'b1;
    clr_dn = 1'b1;
    @(negedge clk);
    clr_up = 1'b0;
    clr_dn = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc();
    chk("R1 level", ramp_level, 0);
    chk("R1 up_done", up_done, 0);
    chk("R1 dn_done", dn_done, 0);

    // Sweep over every gain code.
    for (int g = 0; g <= GMAX; g++) begin
      int n;
      n = (g == 0) ? 1 : g;
      chip_sb = 1'b1; stage_sb = 1'b1; cyc();
      chk("R7 level in chip standby", ramp_level, 0);
      gain_code = g[GAIN_W-1:0];
      chip_sb = 1'b0; cyc();
      clr_both();
      chk("R5 up cleared", up_done, 0);
      stage_sb = 1'b0; cyc();
      for (int k = 1; k <= n; k++) begin
        tick1();
        chk("R2 up level", ramp_level, (k < g) ? k : g);
        chk("R3 up_done", up_done, (k == n) ? 1 : 0);
      end
      tick1();
      chk("R2 hold after ramp", ramp_level, g);
      chk("R4 no dn_done on up", dn_done, 0);
      clr_up = 1'b1; cyc(); clr_up = 1'b0;
      chk("R5 clr_up", up_done, 0);
      stage_sb = 1'b1; cyc();
      for (int k = 1; k <= n; k++) begin
        tick1();
        chk("R4 down level", ramp_level, (g > k) ? g - k : 0);
        chk("R4 dn_done", dn_done, (k == n) ? 1 : 0);
      end
      chk("R6 no up_done on down", up_done, 0);
    end

    // R5: flags are sticky, and each clear strobe acts on its own flag only.
    repeat (5) cyc();
    chk("R5 dn sticky", dn_done, 1);
    clr_up = 1'b1; cyc(); clr_up = 1'b0;
    chk("R5 clr_up leaves dn", dn_done, 1);
    clr_dn = 1'b1; cyc(); clr_dn = 1'b0;
    chk("R5 clr_dn", dn_done, 0);

    // R5: a set and a clear of the same flag in one cycle leaves it set.
    gain_code = 5'd1;
    stage_sb = 1'b0; cyc();
    ramp_tick = 1'b1; clr_up = 1'b1; cyc();
    ramp_tick = 1'b0; clr_up = 1'b0;
    chk("R5 set wins up_done", up_done, 1);
    chk("R5 set wins level", ramp_level, 1);

    // R10: a tick in the same cycle as a start does not step.
    stage_sb = 1'b1; ramp_tick = 1'b1; cyc(); ramp_tick = 1'b0;
    chk("R10 no step on start", ramp_level, 1);
    tick1();
    chk("R10 next tick steps", ramp_level, 0);
    chk("R4 dn_done after R10", dn_done, 1);

    // R6: reversal mid-ramp.
    clr_both();
    gain_code = 5'd10;
    stage_sb = 1'b0; cyc();
    repeat (4) tick1();
    chk("R6 partial up", ramp_level, 4);
    stage_sb = 1'b1; cyc();
    for (int k = 1; k <= 4; k++) begin
      tick1();
      chk("R6 reverse level", ramp_level, 4 - k);
      chk("R6 dn_done", dn_done, (k == 4) ? 1 : 0);
      chk("R6 up_done stays 0", up_done, 0);
    end

    // R11: gain lowered below the level during an up ramp.
    clr_both();
    stage_sb = 1'b0; cyc();
    repeat (6) tick1();
    chk("R11 level before drop", ramp_level, 6);
    gain_code = 5'd3;
    for (int k = 1; k <= 3; k++) begin
      tick1();
      chk("R11 level toward gain", ramp_level, 6 - k);
      chk("R11 up_done", up_done, (k == 3) ? 1 : 0);
    end

    // R9: sleep pauses a down ramp.
    clr_both();
    stage_sb = 1'b1; cyc();
    sleep_req = 1'b1;
    repeat (3) tick1();
    chk("R9 level held in sleep", ramp_level, 3);
    chk("R9 no flag in sleep", dn_done, 0);
    sleep_req = 1'b0;
    tick1();
    chk("R9 resume", ramp_level, 2);

    // R7: chip standby forces zero and blocks flags.
    chip_sb = 1'b1; cyc();
    chk("R7 forced zero", ramp_level, 0);
    clr_both();
    stage_sb = 1'b0; cyc(); tick1();
    stage_sb = 1'b1; cyc(); tick1();
    chk("R7 level stays 0", ramp_level, 0);
    chk("R7 no up_done", up_done, 0);
    chk("R7 no dn_done", dn_done, 0);

    // R8: leaving chip standby with the stage powered starts an up ramp.
    gain_code = 5'd4;
    stage_sb = 1'b0; cyc();
    chip_sb = 1'b0; cyc();
    tick1();
    chk("R8 first step", ramp_level, 1);
    tick1();
    chk("R8 second step", ramp_level, 2);

    finish_run();
  end

endmodule